// File: doc/BRIEF.md
# Programmable-Width System Bus Interface

This unit sits between a 32-bit core request port and an external memory and I/O bus that runs at an integer fraction of the core clock. An internal divider produces one enable pulse per bus cycle. The unit changes its external state only on these pulses.

Four region registers set the behaviour of each address range. Each register holds a base, a compare mask, a port-width code and a turnaround count. When the unit accepts a request, it decodes the address and looks up the region. A 32-bit word is then split into one, two or four external beats. The unit steers the bytes onto the low lanes of the bus in little- or big-endian order. For a read, it rebuilds the word from the beats. A burst moves four consecutive words. After a read, the unit keeps the bus idle for the programmed number of turnaround cycles before it starts the next transaction.

Top module: `sysbus_biu`

## Requirements
- R1: `xb_tick` is high for one core cycle in every DIV core cycles. `xb_cs`, `xb_we` and `xb_addr` change only at a rising edge where `xb_tick` is high.
- R2: The regions are checked in index order, and the lowest-numbered match sets the width and turnaround. A region matches when `((addr ^ base) & mask) == 0`. An address that matches no region uses 32-bit width and zero turnaround.
- R3: Width codes: 0 is 8 bits (four beats per word), 1 is 16 bits (two beats per word), and 2 or 3 is 32 bits (one beat). Address bits [1:0] are ignored. The address of beat k is the word address plus k times the port byte count. Each beat lasts exactly one bus cycle, with `xb_cs` high.
- R4: On writes, the piece for a narrow port goes on the low lanes of `xb_wdata`, and the unused lanes are zero. Little-endian: byte offset o of the word is word bits [8o+7:8o] and sits on lane o mod port-bytes. Big-endian: byte offset o is word bits [8(3-o)+7:8(3-o)] and sits on lane (port-bytes-1-(o mod port-bytes)).
- R5: Reads are reassembled with the same byte-to-lane mapping as R4. The full word appears on `rd_data` with a one-cycle `rd_valid` pulse in the core cycle after the tick that ends the word's last beat.
- R6: A burst transfers four words at word addresses +0, +4, +8 and +12. Each word is expanded into beats as in R3. For a read burst, `rd_valid` pulses once per word, in address order.
- R7: For a burst write, the first word is taken from `req_wdata` when the request is accepted. Each later word is taken at a core cycle where `wr_take` is high. `wr_take` is high only at the tick that ends the last beat of a non-final word.
- R8: After a read, the unit inserts exactly turnaround+1 idle bus cycles before the next beat. After a write, it inserts exactly one.
- R9: While reset is applied, `xb_cs`, `rd_valid` and `wr_take` are low.
- R10: `req_ready` is high only in a tick cycle while the unit is idle. A request is accepted only when `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_big_endian | input | 1 | Byte order: 1 big-endian, 0 little-endian |
| rg_base | input | NREG*32 | Region base addresses, region i at [32i+31:32i] |
| rg_mask | input | NREG*32 | Region compare masks |
| rg_width | input | NREG*2 | Region port-width codes |
| rg_turn | input | NREG*2 | Region read turnaround counts in bus cycles |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_burst | input | 1 | Four-word burst |
| req_addr | input | 32 | Byte address of the first word |
| req_wdata | input | 32 | Write word |
| wr_take | output | 1 | Next burst write word taken this cycle |
| rd_valid | output | 1 | Read word ready |
| rd_data | output | 32 | Reassembled read word |
| xb_tick | output | 1 | Bus cycle enable |
| xb_cs | output | 1 | Beat in progress |
| xb_we | output | 1 | Beat is a write |
| xb_addr | output | 32 | Byte address of the current beat |
| xb_wdata | output | 32 | Steered write piece |
| xb_rdata | input | 32 | Read piece from the bus |

## Verification
Each failure mode shows at the ports within one transaction:
- **Wrong beat counter or width latch:** the count of `xb_cs` ticks is wrong, or a beat address steps by the wrong amount. This shows before the word completes.
- **Byte-order fault:** a lane piece of `xb_wdata` is misplaced, or `rd_data` holds swapped bytes. This shows in the first rebuilt word.
- **Faulty turnaround counter or idle path:** the count of idle bus cycles before the next beat is wrong. This shows within a few bus cycles of the read's final beat.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_BEAT, ST_TURN} biu_state_e;

  function automatic logic [2:0] port_bytes(input logic [1:0] wc);
    case (wc)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] beats_per_word(input logic [1:0] wc);
    case (wc)
      2'd0:    return 3'd4;
      2'd1:    return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] wc);
    case (wc)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // bit position in the word of the piece carried by a given beat
  function automatic logic [4:0] lane_shift(input logic [1:0] wc, input logic [1:0] beat,
                                            input logic big);
    int b;
    int s;
    b = int'(port_bytes(wc));
    s = big ? (4 - (int'(beat) + 1) * b) * 8 : int'(beat) * b * 8;
    return s[4:0];
  endfunction

  function automatic logic [31:0] pick_piece(input logic [31:0] word, input logic [1:0] wc,
                                             input logic [1:0] beat, input logic big);
    return (word >> lane_shift(wc, beat, big)) & lane_mask(wc);
  endfunction

  function automatic logic [31:0] merge_piece(input logic [31:0] acc, input logic [31:0] piece,
                                              input logic [1:0] wc, input logic [1:0] beat,
                                              input logic big);
    logic [4:0] s;
    s = lane_shift(wc, beat, big);
    return (acc & ~(lane_mask(wc) << s)) | ((piece & lane_mask(wc)) << s);
  endfunction

  function automatic logic [31:0] beat_offset(input logic [1:0] wc, input logic [1:0] beat);
    return {30'd0, beat} * {29'd0, port_bytes(wc)};
  endfunction

endpackage

// File: rtl/sysbus_tick_gen.sv
module sysbus_tick_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt == TOP) cnt <= '0;
    else                 cnt <= cnt + CW'(1);
  end

  assign tick = (cnt == TOP);
endmodule

// File: rtl/sysbus_region_dec.sv
module sysbus_region_dec #(
  parameter int NREG = 4
) (
  input  logic [31:0]        addr,
  input  logic [NREG*32-1:0] base,
  input  logic [NREG*32-1:0] mask,
  input  logic [NREG*2-1:0]  width,
  input  logic [NREG*2-1:0]  turn,
  output logic [1:0]         wc,
  output logic [1:0]         tc
);
  logic [NREG-1:0] hit;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_match
      assign hit[i] = (((addr ^ base[i*32 +: 32]) & mask[i*32 +: 32]) == 32'd0);
    end
  endgenerate

  // walk downward so the lowest matching index is written last
  always_comb begin
    wc = 2'd2;
    tc = 2'd0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        wc = width[i*2 +: 2];
        tc = turn[i*2 +: 2];
      end
    end
  end
endmodule

// File: rtl/sysbus_lane.sv
module sysbus_lane
  import sysbus_pkg::*;
(
  input  logic [31:0] wbuf,
  input  logic [31:0] acc,
  input  logic [31:0] rdata,
  input  logic [1:0]  wc,
  input  logic [1:0]  beat,
  input  logic        big,
  output logic [31:0] wdata_out,
  output logic [31:0] acc_next
);
  assign wdata_out = pick_piece(wbuf, wc, beat, big);
  assign acc_next  = merge_piece(acc, rdata, wc, beat, big);
endmodule

// File: rtl/sysbus_biu.sv
module sysbus_biu
  import sysbus_pkg::*;
#(
  parameter int NREG        = 4,
  parameter int DIV         = 2,
  parameter int BURST_WORDS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_big_endian,
  input  logic [NREG*32-1:0] rg_base,
  input  logic [NREG*32-1:0] rg_mask,
  input  logic [NREG*2-1:0]  rg_width,
  input  logic [NREG*2-1:0]  rg_turn,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_burst,
  input  logic [31:0]        req_addr,
  input  logic [31:0]        req_wdata,
  output logic               wr_take,
  output logic               rd_valid,
  output logic [31:0]        rd_data,
  output logic               xb_tick,
  output logic               xb_cs,
  output logic               xb_we,
  output logic [31:0]        xb_addr,
  output logic [31:0]        xb_wdata,
  input  logic [31:0]        xb_rdata
);
  localparam int WW = (BURST_WORDS > 2) ? $clog2(BURST_WORDS) : 1;
  localparam logic [WW-1:0] LAST_WORD = WW'(BURST_WORDS - 1);

  biu_state_e  st;
  logic [31:0] cur_addr, wbuf, acc, rdd_q;
  logic [1:0]  beat, wc, turn, tcnt, dec_wc, dec_tc;
  logic [WW-1:0] word;
  logic        is_wr, is_burst, big, rdv_q;

  // named internal events
  logic        idle_w, beating, turning, beat_last, word_last, accept;
  logic [2:0]  beat_total;
  logic [31:0] acc_next, lane_wdata;

  sysbus_tick_gen #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(xb_tick));

  sysbus_region_dec #(.NREG(NREG)) u_dec (
    .addr(req_addr), .base(rg_base), .mask(rg_mask), .width(rg_width), .turn(rg_turn),
    .wc(dec_wc), .tc(dec_tc)
  );

  sysbus_lane u_lane (
    .wbuf(wbuf), .acc(acc), .rdata(xb_rdata), .wc(wc), .beat(beat), .big(big),
    .wdata_out(lane_wdata), .acc_next(acc_next)
  );

  assign idle_w     = (st == ST_IDLE);
  assign beating    = (st == ST_BEAT);
  assign turning    = (st == ST_TURN);
  assign beat_total = beats_per_word(wc);
  assign beat_last  = ({1'b0, beat} == beat_total - 3'd1);
  assign word_last  = !is_burst || (word == LAST_WORD);
  assign req_ready  = xb_tick && idle_w;
  assign accept     = req_ready && req_valid;
  assign wr_take    = xb_tick && beating && is_wr && beat_last && !word_last;

  assign xb_cs    = beating;
  assign xb_we    = beating && is_wr;
  assign xb_addr  = cur_addr + beat_offset(wc, beat);
  assign xb_wdata = lane_wdata;
  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_addr <= '0;
      wbuf     <= '0;
      acc      <= '0;
      rdd_q    <= '0;
      beat     <= '0;
      word     <= '0;
      wc       <= 2'd2;
      turn     <= '0;
      tcnt     <= '0;
      is_wr    <= 1'b0;
      is_burst <= 1'b0;
      big      <= 1'b0;
      rdv_q    <= 1'b0;
    end else begin
      rdv_q <= 1'b0;
      if (accept) begin
        st       <= ST_BEAT;
        cur_addr <= req_addr & 32'hFFFF_FFFC;
        beat     <= '0;
        word     <= '0;
        is_wr    <= req_write;
        is_burst <= req_burst;
        wc       <= dec_wc;
        turn     <= dec_tc;
        big      <= cfg_big_endian;
        wbuf     <= req_wdata;
        acc      <= '0;
      end else if (xb_tick && beating) begin
        if (!beat_last) begin
          beat <= beat + 2'd1;
          if (!is_wr) acc <= acc_next;
        end else begin
          beat <= '0;
          acc  <= '0;
          if (!is_wr) begin
            rdd_q <= acc_next;
            rdv_q <= 1'b1;
          end
          if (!word_last) begin
            word     <= word + WW'(1);
            cur_addr <= cur_addr + 32'd4;
            if (is_wr) wbuf <= req_wdata;
          end else if (!is_wr && turn != 2'd0) begin
            st   <= ST_TURN;
            tcnt <= turn;
          end else begin
            st <= ST_IDLE;
          end
        end
      end else if (xb_tick && turning) begin
        if (tcnt == 2'd1) st <= ST_IDLE;
        else              tcnt <= tcnt - 2'd1;
      end
    end
  end
endmodule

// File: rtl/sysbus_biu_chk.sv
module sysbus_biu_chk #(
  parameter int DIV = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       xb_tick,
  input logic       xb_cs,
  input logic       xb_we,
  input logic       req_ready,
  input logic       rd_valid,
  input logic       wr_take,
  input logic       in_turn,
  input logic [1:0] beat_idx,
  input logic [2:0] beat_total
);
  p_cs_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !xb_tick |=> $stable(xb_cs));

  generate
    if (DIV > 1) begin : g_gap
      p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        xb_tick |=> !xb_tick);
    end
  endgenerate

  p_beat_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xb_cs |-> ({1'b0, beat_idx} < beat_total));

  p_rdv_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(xb_tick && xb_cs && !xb_we));

  p_take_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (xb_tick && xb_cs && xb_we));

  p_turn_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_turn |-> !xb_cs);

  p_turn_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_turn) |-> $past(xb_cs && !xb_we));

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!xb_cs && !in_turn));
endmodule

bind sysbus_biu sysbus_biu_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .xb_tick(xb_tick), .xb_cs(xb_cs), .xb_we(xb_we),
  .req_ready(req_ready), .rd_valid(rd_valid), .wr_take(wr_take), .in_turn(turning),
  .beat_idx(beat), .beat_total(beat_total)
);

// File: tb/sysbus_biu_tb_top.sv
module sysbus_biu_tb_top;
  localparam int NREG = 4;
  localparam int DIV  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NREG*32-1:0] rg_base, rg_mask;
  logic [NREG*2-1:0]  rg_width, rg_turn;
  logic cfg_big_endian = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata;
  logic req_ready, wr_take, rd_valid, xb_tick, xb_cs, xb_we;
  logic [31:0] rd_data, xb_addr, xb_wdata, xb_rdata;

  // region 3 overlaps region 0 on 0x11xx_xxxx; region 0 must win
  assign rg_base  = {32'h1100_0000, 32'h3000_0000, 32'h2000_0000, 32'h1000_0000};
  assign rg_mask  = {32'hFF00_0000, 32'hF000_0000, 32'hF000_0000, 32'hFE00_0000};
  assign rg_width = {2'd1, 2'd2, 2'd1, 2'd0};
  assign rg_turn  = {2'd0, 2'd3, 2'd1, 2'd2};

  function automatic logic [31:0] rd_pat(input logic [31:0] a);
    return {a[7:0] ^ 8'h3C, a[7:0] ^ 8'h5A, a[7:0] + 8'h11, a[7:0] ^ 8'hC3};
  endfunction
  assign xb_rdata = rd_pat(xb_addr);

  logic [31:0] wpat [0:3];
  int wi = 0;
  logic take_seen = 1'b0;
  assign req_wdata = wpat[wi];

  sysbus_biu #(.NREG(NREG), .DIV(DIV), .BURST_WORDS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_big_endian(cfg_big_endian),
    .rg_base(rg_base), .rg_mask(rg_mask), .rg_width(rg_width), .rg_turn(rg_turn),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_burst(req_burst), .req_addr(req_addr), .req_wdata(req_wdata),
    .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data),
    .xb_tick(xb_tick), .xb_cs(xb_cs), .xb_we(xb_we), .xb_addr(xb_addr),
    .xb_wdata(xb_wdata), .xb_rdata(xb_rdata)
  );

  // bus monitor
  logic [31:0] bt_addr [0:255];
  logic [31:0] bt_data [0:255];
  logic        bt_we   [0:255];
  int          bt_gap  [0:255];
  logic [31:0] rw [0:63];
  int bn = 0, rn = 0, idle_run = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (xb_tick) begin
        if (xb_cs) begin
          if (bn < 256) begin
            bt_addr[bn] = xb_addr;
            bt_data[bn] = xb_wdata;
            bt_we[bn]   = xb_we;
            bt_gap[bn]  = idle_run;
          end
          bn++;
          idle_run = 0;
        end else begin
          idle_run++;
        end
      end
      if (rd_valid) begin
        if (rn < 64) rw[rn] = rd_data;
        rn++;
      end
    end
  end

  // next burst write word after each take
  always @(negedge clk) begin
    if (take_seen && wi < 3) wi++;
    take_seen = wr_take;
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic wr, input logic bu, input logic be);
    @(negedge clk);
    req_addr = a;
    req_write = wr;
    req_burst = bu;
    cfg_big_endian = be;
    for (int i = 0; i < 4; i++) wpat[i] = (a ^ 32'hA5C3_5A3C) + 32'(i) * 32'h1111_1111;
    wi = 0;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (bu) wi = 1;
  endtask

  // bus value expected for beat k of a word (byte order per R4)
  function automatic logic [31:0] exp_piece(input logic [31:0] w, input int bw, input int k,
                                            input bit be);
    logic [31:0] r;
    r = '0;
    for (int j = 0; j < bw; j++) begin
      int o, lane, pos;
      o = k * bw + j;
      lane = be ? bw - 1 - j : j;
      pos = be ? 3 - o : o;
      r[8*lane +: 8] = w[8*pos +: 8];
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [31:0] wa, input int bw, input bit be);
    logic [31:0] r, p;
    r = '0;
    for (int o = 0; o < 4; o++) begin
      int k, j, lane, pos;
      k = o / bw;
      j = o % bw;
      lane = be ? bw - 1 - j : j;
      pos = be ? 3 - o : o;
      p = rd_pat(wa + 32'(k * bw));
      r[8*pos +: 8] = p[8*lane +: 8];
    end
    return r;
  endfunction

  // addr, write, burst, big, expected width code
  localparam logic [36:0] VEC [0:9] = '{
    {32'h1000_0040, 1'b0, 1'b0, 1'b0, 2'd0},
    {32'h1000_0042, 1'b1, 1'b0, 1'b1, 2'd0},
    {32'h2000_0010, 1'b0, 1'b0, 1'b1, 2'd1},
    {32'h2000_0020, 1'b1, 1'b0, 1'b0, 2'd1},
    {32'h3000_0008, 1'b0, 1'b0, 1'b0, 2'd2},
    {32'h4000_0100, 1'b1, 1'b0, 1'b1, 2'd2},
    {32'h1000_0080, 1'b0, 1'b1, 1'b1, 2'd0},
    {32'h2000_0100, 1'b1, 1'b1, 1'b0, 2'd1},
    {32'h4000_0200, 1'b0, 1'b1, 1'b0, 2'd2},
    {32'h1100_0030, 1'b0, 1'b0, 1'b1, 2'd0}
  };

  logic done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int b0, r0, tk;
    for (int i = 0; i < 4; i++) wpat[i] = '0;
    repeat (4) @(negedge clk);
    // R9 reset state
    check(xb_cs == 1'b0, "R9 cs in reset", 32'(xb_cs), 32'd0);
    check(rd_valid == 1'b0, "R9 rd_valid in reset", 32'(rd_valid), 32'd0);
    check(wr_take == 1'b0, "R9 wr_take in reset", 32'(wr_take), 32'd0);
    rst_n = 1'b1;

    // R1 tick rate
    tk = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (xb_tick) tk++;
    end
    check(tk == 20 / DIV, "R1 tick count", 32'(tk), 32'(20 / DIV));

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 10; v++) begin
      logic [31:0] a, wa;
      logic wr, bu, be;
      int wcx, bw, nbt, nw;
      a = VEC[v][36:5];
      wr = VEC[v][4];
      bu = VEC[v][3];
      be = VEC[v][2];
      wcx = int'(VEC[v][1:0]);
      bw = (wcx == 0) ? 1 : (wcx == 1) ? 2 : 4;
      nbt = 4 / bw;
      nw = bu ? 4 : 1;
      b0 = bn;
      r0 = rn;
      issue(a, wr, bu, be);
      repeat (60) @(negedge clk);
      check(bn - b0 == nbt * nw, "R2 R3 beat count", 32'(bn - b0), 32'(nbt * nw));
      for (int w = 0; w < nw; w++) begin
        wa = (a & 32'hFFFF_FFFC) + 32'(4 * w);
        for (int k = 0; k < nbt; k++) begin
          int ix;
          ix = b0 + w * nbt + k;
          check(bt_addr[ix] == wa + 32'(k * bw), "R3 R6 beat address", bt_addr[ix],
                wa + 32'(k * bw));
          check(bt_we[ix] == wr, "R3 beat direction", 32'(bt_we[ix]), 32'(wr));
          if (wr)
            check(bt_data[ix] == exp_piece(wpat[w], bw, k, be), "R4 R7 write lanes",
                  bt_data[ix], exp_piece(wpat[w], bw, k, be));
        end
        if (!wr)
          check(rw[r0 + w] == exp_read(wa, bw, be), "R5 R6 read word", rw[r0 + w],
                exp_read(wa, bw, be));
      end
      if (!wr) check(rn - r0 == nw, "R6 read word count", 32'(rn - r0), 32'(nw));
    end

    // R10 no acceptance while busy
    issue(32'h1000_0000, 1'b0, 1'b0, 1'b0);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(!(req_ready && xb_cs), "R10 ready while busy", 32'(req_ready), 32'd0);
    end
    repeat (40) @(negedge clk);

    // R8 read (turn 2) then write: 3 idle bus cycles
    b0 = bn;
    issue(32'h1000_0000, 1'b0, 1'b0, 1'b0);
    issue(32'h1000_0004, 1'b1, 1'b0, 1'b0);
    repeat (60) @(negedge clk);
    check(bt_gap[b0 + 4] == 3, "R8 gap after read turn 2", 32'(bt_gap[b0 + 4]), 32'd3);

    // R8 write then write in a region with turn 1: 1 idle bus cycle
    b0 = bn;
    issue(32'h2000_0000, 1'b1, 1'b0, 1'b0);
    issue(32'h2000_0008, 1'b1, 1'b0, 1'b0);
    repeat (60) @(negedge clk);
    check(bt_gap[b0 + 2] == 1, "R8 gap after write", 32'(bt_gap[b0 + 2]), 32'd1);

    // R8 read (turn 3) then read: 4 idle bus cycles
    b0 = bn;
    issue(32'h3000_0000, 1'b0, 1'b0, 1'b0);
    issue(32'h4000_0000, 1'b0, 1'b0, 1'b0);
    repeat (60) @(negedge clk);
    check(bt_gap[b0 + 1] == 4, "R8 gap after read turn 3", 32'(bt_gap[b0 + 1]), 32'd4);

    // R2 default region has zero turnaround
    b0 = bn;
    issue(32'h4000_0010, 1'b0, 1'b0, 1'b0);
    issue(32'h4000_0014, 1'b0, 1'b0, 1'b0);
    repeat (60) @(negedge clk);
    check(bt_gap[b0 + 1] == 1, "R2 default turnaround", 32'(bt_gap[b0 + 1]), 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule